// File: doc/BRIEF.md
# Charge Current Switching Modulator

This block drives the single control line that lets charge current flow into a battery pack. When the charge sequencer enables it during the fast or the top-off phase, it runs in one of two ways. In switch-mode it is a two-threshold (bang-bang) regulator. Two comparator flags report whether the sense-resistor voltage is under the lower threshold or over the upper one. The output turns on for the first, turns off for the second and keeps its level between them. In gate mode an outside regulator sets the current, so the comparator flags are ignored and the output simply stays on while charging is enabled.

In the top-off phase a slow envelope is laid over either mode. The output may conduct for a short window of slow ticks and is then forced off for a longer window, over and over. With the default 4-tick-on and 30-tick-off setting, the average current is cut to roughly one eighth. The envelope always starts at the beginning of its conducting window when top-off is entered.

The output comes from a register, so a comparator pulse that falls between clock edges has no effect. A minimum dwell count spaces out ordinary transitions, which keeps the switching frequency under a ceiling of about 300 kHz. To meet that ceiling, set `MIN_DWELL` to at least the clock frequency divided by 600 kHz. Forced turn-off never waits: disabling, the top-off off-window and an illegal flag pair all take effect at once.

Top module: `chg_mod_ctrl`

## Requirements
- R1: While reset is asserted, and on the first edge after it is released with all inputs low, `mod_out` is 0 and the envelope sits at the start of its conducting window.
- R2: In switch-mode, enabled, with only `sns_lo_flag` high and the dwell count expired, `mod_out` is 1 after the next clock edge.
- R3: In switch-mode, enabled, with only `sns_hi_flag` high and the dwell count expired, `mod_out` is 0 after the next clock edge.
- R4: In switch-mode, enabled, with both flags low, `mod_out` keeps its previous value.
- R5: In switch-mode, with both flags high at once (an illegal pair), `mod_out` is 0 after the next clock edge, even while the dwell count is running.
- R6: In gate mode (`ext_gate` = 1), enabled and dwell expired, `mod_out` is 1 after the next edge, whatever the two flags show.
- R7: With `chg_en` = 0, `mod_out` is 0 after the next edge, and the flags and mode select have no effect.
- R8: In top-off (`chg_en` = 1, `topoff_phase` = 1), the envelope position advances by one on each `slow_tick`. At positions 0 to ON_TICKS-1 the output may conduct. At positions ON_TICKS to ON_TICKS+OFF_TICKS-1 it is forced to 0. After the last position the envelope wraps to 0. The envelope position only changes on a tick.
- R9: The envelope position returns to 0 whenever top-off is not active, so each entry into top-off starts a full conducting window.
- R10: After any transition of `mod_out`, no turn-on and no sense-driven turn-off happens for MIN_DWELL clock cycles. Forced turn-offs (R5, R7, R8) are never delayed.
- R11: `mod_out` changes only at a clock edge: a flag pulse that starts and ends between two edges leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chg_en | input | 1 | Charging enabled by the sequencer (fast or top-off) |
| topoff_phase | input | 1 | 1 = top-off phase, 0 = fast phase |
| ext_gate | input | 1 | 1 = gate an external regulator, 0 = switch-mode regulation |
| sns_lo_flag | input | 1 | Sense voltage is below the lower threshold |
| sns_hi_flag | input | 1 | Sense voltage is above the upper threshold |
| slow_tick | input | 1 | One-cycle pulse marking one envelope time unit |
| mod_out | output | 1 | Charge current switch control, 1 = conduct |

## Verification
The bench targets the points where the turn-on and turn-off conditions meet. A design that treated the band between the thresholds as "off" would chop the current on every ripple. A design that let the dwell count hold back a forced turn-off would keep conducting for several cycles after being disabled or after an illegal flag pair. The bench checks that the envelope turns off exactly after ON_TICKS ticks and turns back on exactly at the wrap. A counter that did not restart on a fresh entry into top-off would cut the first window short, and the bench catches that. A flag pulse between edges tests that the output is registered, since an output built from logic alone would follow the pulse.

// File: rtl/chg_mod_pkg.sv
package chg_mod_pkg;

  // Request handed from the sense arbiter to the dwell register.
  typedef enum logic [1:0] {
    REQ_HOLD = 2'd0,  // keep current level
    REQ_ON   = 2'd1,  // sense-driven turn-on
    REQ_OFF  = 2'd2,  // sense-driven turn-off
    REQ_KILL = 2'd3   // forced turn-off, bypasses dwell
  } mod_req_e;

  // Two-threshold decision for an enabled, unmasked cycle.
  function automatic mod_req_e sense_request(input logic gate_mode,
                                             input logic lo_flag,
                                             input logic hi_flag);
    if (gate_mode)             return REQ_ON;
    if (lo_flag && hi_flag)    return REQ_KILL;
    if (lo_flag)               return REQ_ON;
    if (hi_flag)               return REQ_OFF;
    return REQ_HOLD;
  endfunction

  // Level a request asks for, given the present level.
  function automatic logic requested_level(input mod_req_e req, input logic cur);
    case (req)
      REQ_ON:   return 1'b1;
      REQ_OFF:  return 1'b0;
      REQ_KILL: return 1'b0;
      default:  return cur;
    endcase
  endfunction

  // Envelope conducting window test.
  function automatic logic in_on_window(input int unsigned pos, input int unsigned on_len);
    return pos < on_len;
  endfunction

endpackage

// File: rtl/chg_topoff_env.sv
module chg_topoff_env
  import chg_mod_pkg::*;
#(
  parameter int unsigned ON_TICKS  = 4,
  parameter int unsigned OFF_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic tick,
  output logic env_open
);
  localparam int unsigned PERIOD = ON_TICKS + OFF_TICKS;
  localparam int unsigned CW     = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] env_pos;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      env_pos <= '0;
    end else if (!active) begin
      env_pos <= '0;
    end else if (tick) begin
      env_pos <= (env_pos == LAST) ? '0 : env_pos + 1'b1;
    end
  end

  assign env_open = in_on_window(32'(env_pos), ON_TICKS);

  p_env_range_r8: assert property (@(posedge clk) disable iff (!rst_n)
    32'(env_pos) < PERIOD);

  p_env_still_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !tick) |=> $stable(env_pos));

  p_env_home_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> env_pos == '0);

endmodule

// File: rtl/chg_sense_arbiter.sv
module chg_sense_arbiter
  import chg_mod_pkg::*;
(
  input  logic     chg_en,
  input  logic     topoff_phase,
  input  logic     env_open,
  input  logic     ext_gate,
  input  logic     lo_flag,
  input  logic     hi_flag,
  output mod_req_e req
);
  logic masked;

  // Disabled, or inside the top-off off-window: forced off.
  assign masked = !chg_en || (topoff_phase && !env_open);

  always_comb begin
    if (masked) req = REQ_KILL;
    else        req = sense_request(ext_gate, lo_flag, hi_flag);
  end

endmodule

// File: rtl/chg_dwell_reg.sv
module chg_dwell_reg
  import chg_mod_pkg::*;
#(
  parameter int unsigned MIN_DWELL = 8
) (
  input  logic     clk,
  input  logic     rst_n,
  input  mod_req_e req,
  output logic     mod_q,
  output logic     dwell_free
);
  localparam int unsigned DW   = $clog2(MIN_DWELL + 1);
  localparam int unsigned LOAD = (MIN_DWELL > 0) ? MIN_DWELL - 1 : 0;

  logic [DW-1:0] dwell_cnt;
  logic          want, kill, take, mod_nxt;

  always_comb begin
    want    = requested_level(req, mod_q);
    kill    = (req == REQ_KILL);
    take    = (want != mod_q) && (kill || dwell_cnt == '0);
    mod_nxt = take ? want : mod_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_q     <= 1'b0;
      dwell_cnt <= '0;
    end else begin
      mod_q <= mod_nxt;
      if (take)                 dwell_cnt <= DW'(LOAD);
      else if (dwell_cnt != '0) dwell_cnt <= dwell_cnt - 1'b1;
    end
  end

  assign dwell_free = (dwell_cnt == '0);

  p_dwell_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (dwell_cnt != '0 && req != REQ_KILL) |=> mod_q == $past(mod_q));

  p_kill_now_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req == REQ_KILL) |=> !mod_q);

endmodule

// File: rtl/chg_mod_ctrl.sv
module chg_mod_ctrl
  import chg_mod_pkg::*;
#(
  parameter int unsigned MIN_DWELL = 8,
  parameter int unsigned ON_TICKS  = 4,
  parameter int unsigned OFF_TICKS = 30
) (
  input  logic clk,
  input  logic rst_n,
  input  logic chg_en,
  input  logic topoff_phase,
  input  logic ext_gate,
  input  logic sns_lo_flag,
  input  logic sns_hi_flag,
  input  logic slow_tick,
  output logic mod_out
);
  logic     topoff_act;
  logic     env_open;
  logic     dwell_free;
  mod_req_e req;

  assign topoff_act = chg_en && topoff_phase;

  chg_topoff_env #(.ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS)) u_env (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (topoff_act),
    .tick     (slow_tick),
    .env_open (env_open)
  );

  chg_sense_arbiter u_arb (
    .chg_en       (chg_en),
    .topoff_phase (topoff_phase),
    .env_open     (env_open),
    .ext_gate     (ext_gate),
    .lo_flag      (sns_lo_flag),
    .hi_flag      (sns_hi_flag),
    .req          (req)
  );

  chg_dwell_reg #(.MIN_DWELL(MIN_DWELL)) u_dwell (
    .clk        (clk),
    .rst_n      (rst_n),
    .req        (req),
    .mod_q      (mod_out),
    .dwell_free (dwell_free)
  );

  logic unmasked;
  assign unmasked = chg_en && (!topoff_phase || env_open);

  p_reset_low_r1: assert property (@(posedge clk) !rst_n |=> !mod_out);

  p_lo_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (unmasked && !ext_gate && sns_lo_flag && !sns_hi_flag && dwell_free) |=> mod_out);

  p_hi_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (unmasked && !ext_gate && sns_hi_flag && !sns_lo_flag && dwell_free) |=> !mod_out);

  p_band_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (unmasked && !ext_gate && !sns_lo_flag && !sns_hi_flag) |=> $stable(mod_out));

  p_pair_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (chg_en && !ext_gate && sns_lo_flag && sns_hi_flag) |=> !mod_out);

  p_gate_on_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (unmasked && ext_gate && dwell_free) |=> mod_out);

  p_idle_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !chg_en |=> !mod_out);

  p_env_block_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (topoff_act && !env_open) |=> !mod_out);

endmodule

// File: tb/chg_mod_ctrl_tb.sv
`timescale 1ns/1ps
module chg_mod_ctrl_tb;
  localparam int unsigned MIN_DWELL = 8;
  localparam int unsigned ON_TICKS  = 4;
  localparam int unsigned OFF_TICKS = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic chg_en = 1'b0, topoff_phase = 1'b0, ext_gate = 1'b0;
  logic sns_lo_flag = 1'b0, sns_hi_flag = 1'b0, slow_tick = 1'b0;
  logic mod_out;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  chg_mod_ctrl #(.MIN_DWELL(MIN_DWELL), .ON_TICKS(ON_TICKS), .OFF_TICKS(OFF_TICKS)) u_dut (
    .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .topoff_phase(topoff_phase),
    .ext_gate(ext_gate), .sns_lo_flag(sns_lo_flag), .sns_hi_flag(sns_hi_flag),
    .slow_tick(slow_tick), .mod_out(mod_out)
  );

  // {req[3:0], en, topoff, ext, lo, hi, wait[4:0], expected}
  localparam int NV = 12;
  localparam logic [14:0] VECS [NV] = '{
    {4'd2,  5'b10010, 5'd10, 1'b1},  // below low threshold -> on
    {4'd4,  5'b10000, 5'd10, 1'b1},  // in band -> hold on
    {4'd3,  5'b10001, 5'd10, 1'b0},  // above high threshold -> off
    {4'd4,  5'b10000, 5'd10, 1'b0},  // in band -> hold off
    {4'd2,  5'b10010, 5'd10, 1'b1},
    {4'd5,  5'b10011, 5'd1,  1'b0},  // illegal pair -> off at once
    {4'd2,  5'b10010, 5'd10, 1'b1},
    {4'd7,  5'b00010, 5'd1,  1'b0},  // disabled -> off at once
    {4'd6,  5'b10101, 5'd10, 1'b1},  // gate mode ignores high flag
    {4'd6,  5'b10111, 5'd10, 1'b1},  // gate mode ignores both flags
    {4'd7,  5'b00100, 5'd1,  1'b0},
    {4'd7,  5'b00000, 5'd10, 1'b0}
  };

  function automatic string tag_of(input int r);
    case (r)
      1: return "R1";   2: return "R2";   3: return "R3";   4: return "R4";
      5: return "R5";   6: return "R6";   7: return "R7";   8: return "R8";
      9: return "R9";  10: return "R10"; 11: return "R11";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input logic exp, input string tag);
    compared++;
    if (mod_out !== exp) begin
      mismatched++;
      $display("FAIL %s: mod_out=%0b expected %0b", tag, mod_out, exp);
    end
  endtask

  task automatic drive(input logic [4:0] f);
    {chg_en, topoff_phase, ext_gate, sns_lo_flag, sns_hi_flag} = f;
  endtask

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic tick_once();
    slow_tick = 1'b1;
    @(posedge clk);
    @(negedge clk);
    slow_tick = 1'b0;
  endtask

  initial begin
    #400000;
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run hung, actual running expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    settle(3);
    check(1'b0, "R1 during reset");
    rst_n = 1'b1;
    settle(1);
    check(1'b0, "R1 after release");

    // Table walk
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i][10:6]);
      settle(int'(VECS[i][5:1]));
      check(VECS[i][0], tag_of(int'(VECS[i][14:11])));
    end

    // R10: minimum dwell after a turn-on
    drive(5'b10010);
    settle(1);
    check(1'b1, "R10 turn-on");
    drive(5'b10001);
    settle(MIN_DWELL - 2);
    check(1'b1, "R10 held by dwell");
    settle(2);
    check(1'b0, "R10 released after dwell");

    // R5/R10: forced off bypasses a running dwell
    drive(5'b10010);
    settle(10);
    check(1'b1, "R5 setup on");
    drive(5'b10011);
    settle(1);
    check(1'b0, "R5 pair forces off during dwell");

    // R11: pulse between edges has no effect
    drive(5'b10000);
    settle(10);
    check(1'b0, "R11 setup off");
    @(posedge clk);
    #1 sns_lo_flag = 1'b1;
    #0.5 sns_lo_flag = 1'b0;
    settle(2);
    check(1'b0, "R11 glitch ignored");

    // R8: top-off envelope in gate mode
    drive(5'b00000);
    settle(10);
    drive(5'b11100);
    settle(1);
    check(1'b1, "R8 window opens on entry");
    for (int t = 0; t < ON_TICKS - 1; t++) tick_once();
    settle(1);
    check(1'b1, "R8 still in on window");
    tick_once();
    settle(1);
    check(1'b0, "R8 off window after ON_TICKS");
    for (int t = 0; t < OFF_TICKS - 1; t++) tick_once();
    settle(1);
    check(1'b0, "R8 still in off window");
    tick_once();
    settle(1);
    check(1'b1, "R8 wrap reopens window");

    // R9: restart on re-entry
    tick_once();
    drive(5'b10100);
    settle(2);
    check(1'b1, "R9 fast phase gate on");
    drive(5'b11100);
    settle(1);
    for (int t = 0; t < ON_TICKS - 1; t++) tick_once();
    settle(1);
    check(1'b1, "R9 full window after re-entry");
    tick_once();
    settle(1);
    check(1'b0, "R9 window closes at ON_TICKS");

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule